// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transceiver

This block is a full-duplex clocked-serial master. Software writes a byte into a holding register. The block moves that byte into a shifter and shifts it out on a data-out line. At the same time it samples the data-in line into a second shifter. A finished received byte lands in a receive holding register. Because the transmit holding register empties as soon as its byte moves into the shifter, the next byte can be written while the current one is still on the wire, so frames run back to back.

A small register bus gives access to four registers: control, status, data and clock divisor. The status flags are managed by hardware. A data write clears the transmit-empty flag, a data read clears the receive-full flag, and two flags (overrun and transmit-end) are cleared by writing 0, but only after software has read them as 1. An overrun freezes all traffic until software clears it. The transmit-end flag tells software that the final frame has gone out, so the enables can be dropped one bit period later.

Register map (bus_addr): 0 = control {bit2 receive-interrupt enable, bit1 receive enable, bit0 transmit enable}; 1 = status {bit3 transmit-end, bit2 overrun, bit1 receive-full, bit0 transmit-empty}; 2 = data (write: transmit holding, read: receive holding); 3 = divisor. The serial clock idles high, data-out changes on its falling edge and data-in is sampled on its rising edge.

Top module: `ssx_top`

## Requirements
- R1: After reset, the status register reads 0x09 (transmit-end and transmit-empty set), control reads 0x00, the divisor reads 1, sclk and mosi are 1 and rx_irq is 0.
- R2: A data write while transmit-empty is 1 clears transmit-empty. When the byte moves into the shifter (frame start), transmit-empty returns to 1, so a second byte can be written during a frame. It then stays 0 until that byte starts the next frame.
- R3: A data write while transmit-empty is 0 is ignored: the byte is never transmitted and no extra frame runs.
- R4: A frame is 8 bits, MSB first. mosi is updated when sclk falls and is stable while sclk is high, and miso is sampled on each rising edge of sclk.
- R5: The sclk period during a frame is 2*(divisor+1) system clock cycles.
- R6: At the end of a frame, with receive enable set and receive-full 0, the received byte is loaded into the receive holding register and receive-full is set. Reading the data register clears receive-full.
- R7: rx_irq pulses for exactly one cycle when receive-full goes from 0 to 1 while the interrupt enable (control bit2) is set. It never pulses otherwise.
- R8: A frame that completes while receive-full is still 1 sets overrun, and the receive holding register keeps its previous byte.
- R9: While overrun is 1, no frame starts, even with transmit data pending. Once overrun is cleared, the pending byte is sent.
- R10: Transmit-end is set when a frame ends with transmit-empty at 1. It stays 0 across a frame boundary when the next byte is already waiting.
- R11: Writing 0 to status bit2 or bit3 clears that flag only if the latest status read returned it as 1. Writing 1 has no effect, and status writes never change receive-full or transmit-empty.
- R12: Clearing both enable bits aborts a frame at once. sclk and mosi return to 1 on the next cycle, no further sclk edges appear, and receive-full is not set.
- R13: With only transmit enable set, a frame does not touch receive-full or the receive register. With only receive enable set, mosi stays 1 for the whole frame while the byte is still received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle (read side effects apply at the clock edge) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out, idle high |
| miso | input | 1 | Serial data in |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The bench writes a second byte during a frame and then a third byte straight after it. A design that reloads the holding register from a late write sends the wrong byte or runs a third frame, and one that sets transmit-end between chained frames reports completion too early. It forces an overrun with data pending and checks for silence on sclk. A design without the lockout would keep shifting, and one that overwrites the receive register would lose the older byte. It also tries flag clears without a prior read and with ones written, aborts a frame halfway, and runs random bytes at random divisors. These catch clears that fire too easily, lines left low after an abort, and a wrong bit order or clock period.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_DIV  = 2'd3
    } reg_addr_e;

    // control register, bit2..bit0
    typedef struct packed {
        logic irq_en;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    // status register, bit3..bit0
    typedef struct packed {
        logic tx_end;
        logic ovr;
        logic rx_full;
        logic tx_empty;
    } stat_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    localparam stat_t STAT_RESET = '{tx_end: 1'b1, ovr: 1'b0, rx_full: 1'b0, tx_empty: 1'b1};

    function automatic logic link_on(ctrl_t c);
        return c.tx_en | c.rx_en;
    endfunction

    // software clear of the write-zero flags, gated by the read-arm bits
    function automatic stat_t apply_clear(stat_t cur, stat_t armed, logic [3:0] wbits);
        stat_t nxt;
        nxt = cur;
        if (armed.ovr && !wbits[2])
            nxt.ovr = 1'b0;
        if (armed.tx_end && !wbits[3])
            nxt.tx_end = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cnt,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= half_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              halt,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              miso,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sh_state_e         state_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SH_IDLE;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            sclk_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (halt) begin
                state_q <= SH_IDLE;
                sclk_q  <= 1'b1;
                bit_q   <= '0;
            end else if (state_q == SH_IDLE) begin
                if (start) begin
                    state_q <= SH_RUN;
                    tx_sh_q <= load_data;
                    bit_q   <= '0;
                    sclk_q  <= 1'b0;
                end
            end else if (tick) begin
                if (!sclk_q) begin
                    // rising edge: sample the input line
                    sclk_q  <= 1'b1;
                    rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
                end else if (bit_q == LAST_BIT) begin
                    state_q <= SH_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    // falling edge: present the next bit
                    sclk_q  <= 1'b0;
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                    bit_q   <= bit_q + 1'b1;
                end
            end
        end
    end

    assign busy    = (state_q == SH_RUN);
    assign done    = done_q;
    assign sclk    = sclk_q;
    assign mosi    = (busy && tx_en) ? tx_sh_q[DATA_W-1] : 1'b1;
    assign rx_data = rx_sh_q;

endmodule

// File: rtl/ssx_regs.sv
module ssx_regs
    import ssx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              start,
    output logic [DATA_W-1:0] tdr,
    output ctrl_t             ctrl,
    output stat_t             stat,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] rdr,
    output logic              irq
);

    localparam int CTRL_PAD = DATA_W - $bits(ctrl_t);
    localparam int STAT_PAD = DATA_W - $bits(stat_t);

    ctrl_t             ctrl_q;
    stat_t             stat_q, stat_d;
    stat_t             armed_q;
    logic [DATA_W-1:0] tdr_q, rdr_q;
    logic [DIV_W-1:0]  div_q;
    logic              irq_q;

    logic wr_ctrl, wr_stat, wr_data, wr_div, rd_stat, rd_data;
    logic tdr_accept, rx_take, ovr_hit, end_hit;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_stat = bus_wr && (bus_addr == ADDR_STAT);
        wr_data = bus_wr && (bus_addr == ADDR_DATA);
        wr_div  = bus_wr && (bus_addr == ADDR_DIV);
        rd_stat = bus_rd && (bus_addr == ADDR_STAT);
        rd_data = bus_rd && (bus_addr == ADDR_DATA);
    end

    assign tdr_accept = wr_data && stat_q.tx_empty;
    assign start      = !busy && !done && !stat_q.tx_empty && link_on(ctrl_q) && !stat_q.ovr;
    assign ovr_hit    = done && ctrl_q.rx_en && stat_q.rx_full && !rd_data;
    assign rx_take    = done && ctrl_q.rx_en && !ovr_hit;
    assign end_hit    = done && stat_q.tx_empty && !tdr_accept;

    always_comb begin
        stat_d = stat_q;
        if (wr_stat)
            stat_d = apply_clear(stat_q, armed_q, bus_wdata[3:0]);
        if (tdr_accept)
            stat_d.tx_empty = 1'b0;
        if (start)
            stat_d.tx_empty = 1'b1;
        if (rd_data)
            stat_d.rx_full = 1'b0;
        if (rx_take)
            stat_d.rx_full = 1'b1;
        if (ovr_hit)
            stat_d.ovr = 1'b1;
        if (end_hit)
            stat_d.tx_end = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= STAT_RESET;
            armed_q <= '0;
            tdr_q   <= '0;
            rdr_q   <= '0;
            div_q   <= DIV_W'(DIV_RESET);
            irq_q   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= ctrl_q.irq_en && rx_take && !stat_q.rx_full;
            if (wr_stat)
                armed_q <= '0;
            else if (rd_stat)
                armed_q <= stat_q;
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
            if (wr_div)
                div_q <= bus_wdata[DIV_W-1:0];
            if (tdr_accept)
                tdr_q <= bus_wdata;
            if (rx_take)
                rdr_q <= rx_data;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
            ADDR_STAT: bus_rdata = {{STAT_PAD{1'b0}}, stat_q};
            ADDR_DATA: bus_rdata = rdr_q;
            default:   bus_rdata = DATA_W'(div_q);
        endcase
    end

    assign tdr  = tdr_q;
    assign ctrl = ctrl_q;
    assign stat = stat_q;
    assign div  = div_q;
    assign rdr  = rdr_q;
    assign irq  = irq_q;

endmodule

// File: rtl/ssx_top.sv
module ssx_top
    import ssx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              rx_irq
);

    ctrl_t             ctrl;
    stat_t             stat;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tdr, rdr, rx_data;
    logic              start, busy, done, tick, halt;

    assign halt = !link_on(ctrl);

    ssx_regs #(
        .DATA_W   (DATA_W),
        .DIV_W    (DIV_W),
        .DIV_RESET(DIV_RESET)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .done     (done),
        .rx_data  (rx_data),
        .start    (start),
        .tdr      (tdr),
        .ctrl     (ctrl),
        .stat     (stat),
        .div      (div),
        .rdr      (rdr),
        .irq      (rx_irq)
    );

    ssx_clkgen #(
        .DIV_W(DIV_W)
    ) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .half_cnt(div),
        .tick    (tick)
    );

    ssx_shifter #(
        .DATA_W(DATA_W)
    ) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .halt     (halt),
        .tick     (tick),
        .tx_en    (ctrl.tx_en),
        .miso     (miso),
        .load_data(tdr),
        .busy     (busy),
        .done     (done),
        .sclk     (sclk),
        .mosi     (mosi),
        .rx_data  (rx_data)
    );

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              mosi,
    input logic              rx_irq,
    input logic              busy,
    input ctrl_t             ctrl,
    input stat_t             stat,
    input logic [DATA_W-1:0] rdr
);

    a_r12_halt_idle: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.tx_en || ctrl.rx_en) |=> (sclk && mosi && !busy));

    a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && mosi));

    a_r7_irq_only_on_rise: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $rose(stat.rx_full));

    a_r7_irq_when_enabled: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat.rx_full) && $past(ctrl.irq_en)) |-> rx_irq);

    a_r8_ovr_keeps_rdr: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.ovr) |-> $stable(rdr));

    a_r9_ovr_blocks_start: assert property (@(posedge clk) disable iff (rst)
        (stat.ovr && !busy) |=> !busy);

    a_r2_empty_on_load: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> stat.tx_empty);

    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk) && busy && $past(busy) && $stable(ctrl.tx_en)) |-> $stable(mosi));

endmodule

bind ssx_top ssx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sclk  (sclk),
    .mosi  (mosi),
    .rx_irq(rx_irq),
    .busy  (busy),
    .ctrl  (ctrl),
    .stat  (stat),
    .rdr   (rdr)
);

// File: tb/tb_ssx_top.sv
module tb_ssx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, rx_irq;
    logic       miso = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // slave model: shifts out on falling sclk, captures on rising sclk
    logic [31:0] slv_out = 32'hFFFF_FFFF;
    logic [15:0] slv_in = 16'h0;

    // line monitors
    int  rise_cnt = 0;
    int  cyc_since = 0;
    int  last_period = 0;
    int  irq_cnt = 0;
    logic sclk_prev = 1'b1;

    always #10 clk = ~clk;

    ssx_top dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .rx_irq   (rx_irq)
    );

    always @(negedge sclk) begin
        miso = slv_out[31];
        slv_out = {slv_out[30:0], 1'b1};
    end

    always @(posedge sclk) slv_in = {slv_in[14:0], mosi};

    always @(negedge clk) begin
        cyc_since = cyc_since + 1;
        if (sclk === 1'b1 && sclk_prev === 1'b0) begin
            last_period = cyc_since;
            cyc_since = 0;
            rise_cnt = rise_cnt + 1;
        end
        sclk_prev = sclk;
        if (rx_irq === 1'b1)
            irq_cnt = irq_cnt + 1;
    end

    function automatic int exp_period(input int dv);
        return 2 * (dv + 1);
    endfunction

    function automatic logic [7:0] stat_byte(input bit te, input bit ov, input bit rf, input bit em);
        return {4'b0, te, ov, rf, em};
    endfunction

    function automatic int frame_wait(input int dv);
        return 16 * (dv + 1) + 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        int irq0;
        int unsigned seed;
        seed = $urandom(32'd5813);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(sclk === 1'b1 && mosi === 1'b1, "R1 idle lines", {sclk, mosi}, 3);
        check(rx_irq === 1'b0, "R1 irq low", rx_irq, 0);
        rd(2'd1, v); check(v == stat_byte(1, 0, 0, 1), "R1 status reset", v, stat_byte(1, 0, 0, 1));
        rd(2'd0, v); check(v == 8'h00, "R1 control reset", v, 0);
        rd(2'd3, v); check(v == 8'h01, "R1 divisor reset", v, 1);

        // R4 R6 R7 R5: one directed frame
        wr(2'd0, 8'h07);
        slv_out = {8'hA5, 24'hFFFFFF};
        irq0 = irq_cnt;
        wr(2'd2, 8'h3C);
        idle(frame_wait(1));
        check(slv_in[7:0] == 8'h3C, "R4 mosi byte msb first", slv_in[7:0], 8'h3C);
        check(last_period == exp_period(1), "R5 sclk period", last_period, exp_period(1));
        check(irq_cnt - irq0 == 1, "R7 one irq pulse", irq_cnt - irq0, 1);
        rd(2'd1, v); check(v == stat_byte(1, 0, 1, 1), "R6 rx_full set", v, stat_byte(1, 0, 1, 1));
        rd(2'd2, v); check(v == 8'hA5, "R6 R4 received byte", v, 8'hA5);
        rd(2'd1, v); check(v == stat_byte(1, 0, 0, 1), "R6 read clears rx_full", v, stat_byte(1, 0, 0, 1));

        // R11 clear tx_end after reading it as 1 (armed by the read just above)
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v == stat_byte(0, 0, 0, 1), "R11 armed clear of tx_end", v, stat_byte(0, 0, 0, 1));

        // R2 R3 R10 back-to-back frames
        slv_out = {8'h5A, 8'hC3, 16'hFFFF};
        irq0 = irq_cnt;
        rise_cnt = 0;
        wr(2'd2, 8'h81);
        rd(2'd1, v); check(v == stat_byte(0, 0, 0, 1), "R2 byte moved to shifter", v, stat_byte(0, 0, 0, 1));
        wr(2'd2, 8'h6E);
        rd(2'd1, v); check(v == stat_byte(0, 0, 0, 0), "R2 second byte pending", v, stat_byte(0, 0, 0, 0));
        wr(2'd2, 8'hF0);
        idle(30);
        rd(2'd1, v); check(v == stat_byte(0, 0, 1, 1), "R10 no tx_end between chained frames", v, stat_byte(0, 0, 1, 1));
        rd(2'd2, v); check(v == 8'h5A, "R6 first chained byte", v, 8'h5A);
        idle(40);
        check(slv_in == 16'h816E, "R3 only two bytes sent", slv_in, 16'h816E);
        check(rise_cnt == 16, "R3 no third frame", rise_cnt, 16);
        check(irq_cnt - irq0 == 2, "R7 irq per frame", irq_cnt - irq0, 2);
        rd(2'd1, v); check(v == stat_byte(1, 0, 1, 1), "R10 tx_end after last frame", v, stat_byte(1, 0, 1, 1));
        rd(2'd2, v); check(v == 8'hC3, "R6 second chained byte", v, 8'hC3);

        // R8 R9 R11 overrun lockout
        slv_out = {8'h11, 8'h22, 8'h33, 8'hFF};
        wr(2'd2, 8'h01);
        idle(frame_wait(1));
        wr(2'd2, 8'h02);
        idle(frame_wait(1));
        wr(2'd2, 8'h03);
        idle(2);
        rise_cnt = 0;
        idle(40);
        check(rise_cnt == 0, "R9 no sclk during overrun", rise_cnt, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v == stat_byte(0, 1, 1, 0), "R11 unarmed write keeps ovr", v, stat_byte(0, 1, 1, 0));
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check(v == stat_byte(0, 1, 1, 0), "R11 writing ones has no effect", v, stat_byte(0, 1, 1, 0));
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v == stat_byte(0, 0, 1, 1), "R9 ovr cleared and pending byte started", v, stat_byte(0, 0, 1, 1));
        rd(2'd2, v); check(v == 8'h11, "R8 register kept older byte", v, 8'h11);
        idle(frame_wait(1));
        check(slv_in[7:0] == 8'h03, "R9 pending byte sent after clear", slv_in[7:0], 8'h03);
        rd(2'd2, v); check(v == 8'h33, "R9 reception resumed", v, 8'h33);

        // R7 interrupt disabled
        wr(2'd0, 8'h03);
        slv_out = {8'h44, 24'hFFFFFF};
        irq0 = irq_cnt;
        wr(2'd2, 8'h55);
        idle(frame_wait(1));
        check(irq_cnt == irq0, "R7 no irq when disabled", irq_cnt - irq0, 0);
        rd(2'd2, v); check(v == 8'h44, "R6 byte with irq off", v, 8'h44);

        // R13 transmit only, then receive only
        wr(2'd0, 8'h01);
        slv_out = {8'h99, 24'hFFFFFF};
        wr(2'd2, 8'h2D);
        idle(frame_wait(1));
        check(slv_in[7:0] == 8'h2D, "R13 tx only sends", slv_in[7:0], 8'h2D);
        rd(2'd1, v); check(v[1] == 1'b0, "R13 tx only leaves rx_full", v[1], 0);
        rd(2'd2, v); check(v == 8'h44, "R13 tx only keeps receive register", v, 8'h44);
        wr(2'd0, 8'h02);
        slv_out = {8'h6B, 24'hFFFFFF};
        wr(2'd2, 8'h00);
        idle(frame_wait(1));
        check(slv_in[7:0] == 8'hFF, "R13 rx only holds mosi high", slv_in[7:0], 8'hFF);
        rd(2'd2, v); check(v == 8'h6B, "R13 rx only receives", v, 8'h6B);

        // R12 abort mid frame
        wr(2'd0, 8'h03);
        slv_out = {8'h00, 24'h000000};
        wr(2'd2, 8'h00);
        idle(10);
        wr(2'd0, 8'h00);
        check(sclk === 1'b1 && mosi === 1'b1, "R12 lines idle after abort", {sclk, mosi}, 3);
        idle(1);
        rise_cnt = 0;
        idle(40);
        check(rise_cnt == 0, "R12 no sclk after abort", rise_cnt, 0);
        rd(2'd1, v); check(v[1] == 1'b0, "R12 no reception on abort", v[1], 0);

        // random frames at random divisors
        for (int it = 0; it < 20; it++) begin
            int dv;
            logic [7:0] tb_tx, tb_sl;
            dv = int'($urandom % 4);
            tb_tx = 8'($urandom);
            tb_sl = 8'($urandom);
            wr(2'd3, 8'(dv));
            wr(2'd0, 8'h07);
            slv_out = {tb_sl, 24'hFFFFFF};
            irq0 = irq_cnt;
            wr(2'd2, tb_tx);
            idle(frame_wait(dv));
            check(slv_in[7:0] == tb_tx, "R4 random transmit", slv_in[7:0], tb_tx);
            check(last_period == exp_period(dv), "R5 random period", last_period, exp_period(dv));
            check(irq_cnt - irq0 == 1, "R7 random irq", irq_cnt - irq0, 1);
            rd(2'd2, v); check(v == tb_sl, "R6 random receive", v, tb_sl);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule